// File: doc/BRIEF.md
# Seconds Counter with Alarm

This block is a register-mapped real-time seconds counter for a microcontroller. A one-cycle strobe from a slow oscillator (nominally 32768 per second, already brought into the bus clock domain) drives a prescaler. Each time the prescaler wraps, a seconds register of parameter width advances by one. An alarm compare register raises a sticky alarm flag when the count steps onto its value. When the count wraps past its maximum, an overflow flag is raised.

Software uses a simple synchronous register bus. Writes take effect on the clock edge where `bus_wr` is high. Reads are combinational from `bus_addr`. The status flags have no direct clear. Writing the seconds register clears the invalid-time and overflow flags. Writing the alarm register clears the alarm flag. The seconds register can only be loaded while the count-enable bit is clear. Because the count can change between two reads, software should read it twice and compare the results. A control register holds an oscillator enable and a software reset. An interrupt-enable register routes the alarm and overflow flags to one interrupt line.

Register map, by `bus_addr`:
- 0: seconds.
- 1: alarm.
- 2: status.
- 3: control.
- 4: interrupt enable.

Top module: `secs_timer`

## Requirements
- R1: After `rst_n` is released, the registers read as follows: seconds 0, alarm 0, control 0, interrupt enable 0, and status 0x01 (invalid-time set). `irq` is 0.
- R2: A write to address 0 loads the seconds register only while status bit 4 (count enable) is 0. Such a load clears status bit 0 (invalid-time) and status bit 1 (overflow). While count enable is 1, a write to address 0 is ignored and leaves the flags unchanged.
- R3: While control bit 1 (oscillator enable) is 1, count enable is 1, and status bits 0 and 1 are 0, the seconds value rises by exactly one on each 2^PRE_W-th oscillator tick.
- R4: Writing status bit 4 as 0 stops counting and keeps the seconds value. It also returns the prescaler to zero, so a full 2^PRE_W ticks are needed after counting resumes.
- R5: No counting takes place while the invalid-time flag is set or the oscillator enable is 0.
- R6: Status bit 2 (alarm) sets when the seconds value steps onto the alarm register value (address 1). It stays set through later counts. Any write to address 1 clears it.
- R7: When the counter steps past its maximum value, it becomes 0 and sets both the overflow flag and the invalid-time flag. It then holds at 0 until the seconds register is written.
- R8: `irq` equals (alarm flag AND interrupt-enable bit 0) OR (overflow flag AND interrupt-enable bit 1). Writing 0 to address 4 masks both sources.
- R9: While control bit 0 (software reset) is 1, every register except control is held at its R1 value, and writes to those registers have no effect. Control itself stays writable.
- R10: Status bits 0 to 2 are read-only, and a write to address 2 changes only bit 4. Addresses 5 to 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle strobe per slow-oscillator period |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for `bus_addr` |
| irq | output | 1 | Masked interrupt request |

## Verification
A prescaler phase that does not return to zero when counting stops shows up as a seconds increment arriving fewer than 2^PRE_W ticks after counting resumes. That error is visible on the very next read of address 0. A flag that is set, or cleared, in the wrong cycle appears immediately in the status read and in `irq`. A lock on seconds writes that is decoded wrongly shows up in the read that follows the write. A counter that fails to hold after overflow is exposed one prescaler period later, when it reads as nonzero.

// File: rtl/secs_pkg.sv
package secs_pkg;
  typedef enum logic [2:0] {
    A_SEC  = 3'd0,
    A_ALM  = 3'd1,
    A_STAT = 3'd2,
    A_CTRL = 3'd3,
    A_IEN  = 3'd4
  } reg_addr_e;

  // status bit positions
  localparam int ST_TIF = 0;
  localparam int ST_TOF = 1;
  localparam int ST_TAF = 2;
  localparam int ST_TCE = 4;
  // control bit positions
  localparam int CT_SWR = 0;
  localparam int CT_OSC = 1;
  // interrupt enable positions
  localparam int IE_ALM = 0;
  localparam int IE_OVF = 1;
  localparam int N_IRQ  = 2;
endpackage

// File: rtl/secs_prescaler.sv
module secs_prescaler #(
  parameter int PRE_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic             tick,
  output logic             sec_pulse,
  output logic [PRE_W-1:0] phase
);
  localparam logic [PRE_W-1:0] PH_TOP = '1;

  logic [PRE_W-1:0] ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            ph_q <= '0;
    else if (clr || !run)  ph_q <= '0;
    else if (tick)         ph_q <= ph_q + 1'b1;
  end

  assign sec_pulse = run && tick && (ph_q == PH_TOP);
  assign phase     = ph_q;
endmodule

// File: rtl/secs_ctrl.sv
module secs_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_ctrl,
  input  logic       wr_stat,
  input  logic       wr_ien,
  input  logic       wd_swr,
  input  logic       wd_osc,
  input  logic       wd_tce,
  input  logic [1:0] wd_ie,
  output logic       swr,
  output logic       osc_en,
  output logic       tce,
  output logic [1:0] ien
);
  logic       swr_q, osc_q, tce_q;
  logic [1:0] ien_q;

  // control: only the pin reset touches it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swr_q <= 1'b0;
      osc_q <= 1'b0;
    end else if (wr_ctrl) begin
      swr_q <= wd_swr;
      osc_q <= wd_osc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tce_q <= 1'b0;
      ien_q <= '0;
    end else if (swr_q) begin
      tce_q <= 1'b0;
      ien_q <= '0;
    end else begin
      if (wr_stat) tce_q <= wd_tce;
      if (wr_ien)  ien_q <= wd_ie;
    end
  end

  assign swr    = swr_q;
  assign osc_en = osc_q;
  assign tce    = tce_q;
  assign ien    = ien_q;
endmodule

// File: rtl/secs_core.sv
module secs_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         swr,
  input  logic         tce,
  input  logic         sec_pulse,
  input  logic         wr_sec,
  input  logic         wr_alm,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] seconds,
  output logic [W-1:0] alarm,
  output logic         tif,
  output logic         tof,
  output logic         taf
);
  localparam logic [W-1:0] CNT_MAX = '1;

  logic [W-1:0] sec_q, alm_q, sec_nxt;
  logic         tif_q, tof_q, taf_q;
  logic         load_ok, wrap;

  assign load_ok = wr_sec && !tce;
  assign sec_nxt = sec_q + 1'b1;
  assign wrap    = sec_pulse && (sec_q == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q <= '0;
      tif_q <= 1'b1;
      tof_q <= 1'b0;
    end else if (swr) begin
      sec_q <= '0;
      tif_q <= 1'b1;
      tof_q <= 1'b0;
    end else if (load_ok) begin
      sec_q <= wdata;
      tif_q <= 1'b0;
      tof_q <= 1'b0;
    end else if (sec_pulse) begin
      sec_q <= sec_nxt;
      if (wrap) begin
        tif_q <= 1'b1;
        tof_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_q <= '0;
      taf_q <= 1'b0;
    end else if (swr) begin
      alm_q <= '0;
      taf_q <= 1'b0;
    end else if (wr_alm) begin
      alm_q <= wdata;
      taf_q <= 1'b0;
    end else if (sec_pulse && (sec_nxt == alm_q)) begin
      taf_q <= 1'b1;
    end
  end

  assign seconds = sec_q;
  assign alarm   = alm_q;
  assign tif     = tif_q;
  assign tof     = tof_q;
  assign taf     = taf_q;
endmodule

// File: rtl/secs_timer.sv
module secs_timer
  import secs_pkg::*;
#(
  parameter int W     = 32,
  parameter int PRE_W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         osc_tick,
  input  logic         bus_wr,
  input  logic [2:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  output logic         irq
);
  reg_addr_e        addr_e;
  logic             wr_sec, wr_alm, wr_stat, wr_ctrl, wr_ien;
  logic             swr, osc_en, tce, run, sec_pulse;
  logic [1:0]       ien;
  logic [W-1:0]     seconds, alarm;
  logic             tif, tof, taf;
  logic [PRE_W-1:0] phase;
  logic [N_IRQ-1:0] src_flag, src_hit;

  assign addr_e  = reg_addr_e'(bus_addr);
  assign wr_sec  = bus_wr && (addr_e == A_SEC)  && !swr;
  assign wr_alm  = bus_wr && (addr_e == A_ALM)  && !swr;
  assign wr_stat = bus_wr && (addr_e == A_STAT);
  assign wr_ctrl = bus_wr && (addr_e == A_CTRL);
  assign wr_ien  = bus_wr && (addr_e == A_IEN);

  secs_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_ctrl(wr_ctrl),
    .wr_stat(wr_stat),
    .wr_ien (wr_ien),
    .wd_swr (bus_wdata[CT_SWR]),
    .wd_osc (bus_wdata[CT_OSC]),
    .wd_tce (bus_wdata[ST_TCE]),
    .wd_ie  (bus_wdata[1:0]),
    .swr    (swr),
    .osc_en (osc_en),
    .tce    (tce),
    .ien    (ien)
  );

  assign run = osc_en && tce && !tif && !tof;

  secs_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (swr),
    .run      (run),
    .tick     (osc_tick),
    .sec_pulse(sec_pulse),
    .phase    (phase)
  );

  secs_core #(.W(W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .swr      (swr),
    .tce      (tce),
    .sec_pulse(sec_pulse),
    .wr_sec   (wr_sec),
    .wr_alm   (wr_alm),
    .wdata    (bus_wdata),
    .seconds  (seconds),
    .alarm    (alarm),
    .tif      (tif),
    .tof      (tof),
    .taf      (taf)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (addr_e)
      A_SEC:  bus_rdata = seconds;
      A_ALM:  bus_rdata = alarm;
      A_STAT: begin
        bus_rdata[ST_TIF] = tif;
        bus_rdata[ST_TOF] = tof;
        bus_rdata[ST_TAF] = taf;
        bus_rdata[ST_TCE] = tce;
      end
      A_CTRL: begin
        bus_rdata[CT_SWR] = swr;
        bus_rdata[CT_OSC] = osc_en;
      end
      A_IEN:  bus_rdata[1:0] = ien;
      default: bus_rdata = '0;
    endcase
  end

  assign src_flag[IE_ALM] = taf;
  assign src_flag[IE_OVF] = tof;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_irq
    assign src_hit[g] = src_flag[g] & ien[g];
  end

  assign irq = |src_hit;
endmodule

// File: rtl/secs_timer_chk.sv
module secs_timer_chk #(
  parameter int W     = 32,
  parameter int PRE_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_wr,
  input logic [2:0]       bus_addr,
  input logic [W-1:0]     bus_wdata,
  input logic             irq,
  input logic [W-1:0]     seconds,
  input logic [W-1:0]     alarm,
  input logic             tce,
  input logic             tif,
  input logic             tof,
  input logic             taf,
  input logic [1:0]       ien,
  input logic             swr,
  input logic [PRE_W-1:0] phase
);
  logic sec_write;
  assign sec_write = bus_wr && (bus_addr == 3'd0);

  // R2
  sec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_write && !tce && !swr) |=> (seconds == $past(bus_wdata)) && !tif && !tof);

  // R3
  sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tce |=> (seconds == $past(seconds)) || (seconds == $past(seconds) + 1'b1) || (seconds == '0));

  // R4
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tce && !swr && !sec_write) |=> $stable(seconds));

  // R4
  pre_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tce |=> (phase == '0));

  // R5
  invalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tif && !swr && !sec_write) |=> $stable(seconds));

  // R6
  alarm_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(taf) |-> (seconds == alarm));

  // R7
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tof) |-> (seconds == '0) && tif);

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 2'b00) |-> !irq);

  // R9
  swr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swr |=> (seconds == '0) && (alarm == '0) && tif && !tof && !taf && !tce && (ien == 2'b00));
endmodule

bind secs_timer secs_timer_chk #(.W(W), .PRE_W(PRE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .irq      (irq),
  .seconds  (seconds),
  .alarm    (alarm),
  .tce      (tce),
  .tif      (tif),
  .tof      (tof),
  .taf      (taf),
  .ien      (ien),
  .swr      (swr),
  .phase    (phase)
);

// File: tb/sim_secs_timer.sv
module sim_secs_timer;
  localparam int CLK_P = 10;
  localparam int W     = 32;
  localparam int PRE_W = 3;

  localparam logic [1:0] OP_WR = 2'd0;
  localparam logic [1:0] OP_RD = 2'd1;
  localparam logic [1:0] OP_TK = 2'd2;
  localparam logic [1:0] OP_IQ = 2'd3;

  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 54;
  localparam vec_t VEC [NV] = '{
    '{OP_WR, 3'd3, 32'h2,  32'h0,  4'd3},
    '{OP_WR, 3'd2, 32'h10, 32'h0,  4'd5},
    '{OP_TK, 3'd0, 32'd8,  32'h0,  4'd5},
    '{OP_RD, 3'd0, 32'h0,  32'h0,  4'd5},   // R5 invalid blocks
    '{OP_WR, 3'd0, 32'h5,  32'h0,  4'd2},
    '{OP_RD, 3'd0, 32'h0,  32'h0,  4'd2},   // R2 locked while enabled
    '{OP_RD, 3'd2, 32'h0,  32'h11, 4'd2},
    '{OP_WR, 3'd2, 32'h0,  32'h0,  4'd2},
    '{OP_WR, 3'd0, 32'h5,  32'h0,  4'd2},
    '{OP_RD, 3'd2, 32'h0,  32'h0,  4'd2},   // R2 flags cleared
    '{OP_RD, 3'd0, 32'h0,  32'h5,  4'd2},
    '{OP_WR, 3'd1, 32'h7,  32'h0,  4'd6},
    '{OP_WR, 3'd4, 32'h1,  32'h0,  4'd8},
    '{OP_WR, 3'd2, 32'h10, 32'h0,  4'd3},
    '{OP_TK, 3'd0, 32'd8,  32'h0,  4'd3},
    '{OP_RD, 3'd0, 32'h0,  32'h6,  4'd3},   // R3 one step
    '{OP_IQ, 3'd0, 32'h0,  32'h0,  4'd8},
    '{OP_TK, 3'd0, 32'd5,  32'h0,  4'd4},
    '{OP_WR, 3'd2, 32'h0,  32'h0,  4'd4},
    '{OP_TK, 3'd0, 32'd8,  32'h0,  4'd4},
    '{OP_RD, 3'd0, 32'h0,  32'h6,  4'd4},   // R4 stopped
    '{OP_WR, 3'd2, 32'h10, 32'h0,  4'd4},
    '{OP_TK, 3'd0, 32'd7,  32'h0,  4'd4},
    '{OP_RD, 3'd0, 32'h0,  32'h6,  4'd4},   // R4 prescaler restarted at zero
    '{OP_TK, 3'd0, 32'd1,  32'h0,  4'd3},
    '{OP_RD, 3'd0, 32'h0,  32'h7,  4'd3},
    '{OP_RD, 3'd2, 32'h0,  32'h14, 4'd6},   // R6 alarm set
    '{OP_IQ, 3'd0, 32'h0,  32'h1,  4'd8},
    '{OP_TK, 3'd0, 32'd8,  32'h0,  4'd3},
    '{OP_RD, 3'd0, 32'h0,  32'h8,  4'd3},
    '{OP_RD, 3'd2, 32'h0,  32'h14, 4'd6},   // R6 sticky
    '{OP_WR, 3'd4, 32'h0,  32'h0,  4'd8},
    '{OP_IQ, 3'd0, 32'h0,  32'h0,  4'd8},   // R8 masked
    '{OP_WR, 3'd1, 32'd100, 32'h0, 4'd6},
    '{OP_RD, 3'd2, 32'h0,  32'h10, 4'd6},   // R6 cleared by alarm write
    '{OP_RD, 3'd1, 32'h0,  32'd100, 4'd10},
    '{OP_WR, 3'd3, 32'h0,  32'h0,  4'd5},
    '{OP_TK, 3'd0, 32'd8,  32'h0,  4'd5},
    '{OP_RD, 3'd0, 32'h0,  32'h8,  4'd5},   // R5 oscillator off
    '{OP_WR, 3'd3, 32'h2,  32'h0,  4'd7},
    '{OP_WR, 3'd2, 32'h0,  32'h0,  4'd7},
    '{OP_WR, 3'd0, 32'hFFFF_FFFF, 32'h0, 4'd7},
    '{OP_WR, 3'd4, 32'h2,  32'h0,  4'd8},
    '{OP_WR, 3'd2, 32'h10, 32'h0,  4'd7},
    '{OP_TK, 3'd0, 32'd8,  32'h0,  4'd7},
    '{OP_RD, 3'd0, 32'h0,  32'h0,  4'd7},   // R7 wrapped
    '{OP_RD, 3'd2, 32'h0,  32'h13, 4'd7},
    '{OP_IQ, 3'd0, 32'h0,  32'h1,  4'd8},   // R8 overflow source
    '{OP_TK, 3'd0, 32'd8,  32'h0,  4'd7},
    '{OP_RD, 3'd0, 32'h0,  32'h0,  4'd7},   // R7 holds at zero
    '{OP_WR, 3'd2, 32'h0,  32'h0,  4'd2},
    '{OP_WR, 3'd0, 32'h3,  32'h0,  4'd2},
    '{OP_RD, 3'd2, 32'h0,  32'h0,  4'd2},
    '{OP_IQ, 3'd0, 32'h0,  32'h0,  4'd8}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         osc_tick = 1'b0;
  logic         bus_wr = 1'b0;
  logic [2:0]   bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic         irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  secs_timer #(.W(W), .PRE_W(PRE_W)) u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_tick (osc_tick),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .irq      (irq)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input int req, input logic [2:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic do_irq(input int req, input logic exp);
    @(negedge clk);
    #1;
    check(req, {31'b0, irq}, {31'b0, exp});
  endtask

  task automatic do_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); osc_tick = 1'b1;
      @(negedge clk); osc_tick = 1'b0;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    do_rd(1, 3'd0, 32'h0);
    do_rd(1, 3'd1, 32'h0);
    do_rd(1, 3'd2, 32'h1);
    do_rd(1, 3'd3, 32'h0);
    do_rd(1, 3'd4, 32'h0);
    do_irq(1, 1'b0);
    // R10 unmapped address
    do_rd(10, 3'd7, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        OP_WR:   do_wr(VEC[i].addr, VEC[i].data);
        OP_RD:   do_rd(int'(VEC[i].req), VEC[i].addr, VEC[i].exp);
        OP_TK:   do_ticks(int'(VEC[i].data));
        default: do_irq(int'(VEC[i].req), VEC[i].exp[0]);
      endcase
    end

    // R10 status flag bits not writable: write 0x07 leaves invalid clear, enable 0
    do_wr(3'd2, 32'h07);
    do_rd(10, 3'd2, 32'h0);

    // R9 software reset
    do_wr(3'd4, 32'h3);
    do_wr(3'd1, 32'h9);
    do_wr(3'd2, 32'h10);
    do_wr(3'd3, 32'h3);
    do_rd(9, 3'd2, 32'h1);
    do_rd(9, 3'd1, 32'h0);
    do_rd(9, 3'd4, 32'h0);
    do_rd(9, 3'd0, 32'h0);
    do_rd(9, 3'd3, 32'h3);
    do_wr(3'd0, 32'h4);
    do_rd(9, 3'd0, 32'h0);   // R9 write ignored during reset
    do_wr(3'd1, 32'h5);
    do_rd(9, 3'd1, 32'h0);
    do_wr(3'd3, 32'h2);
    do_rd(9, 3'd3, 32'h2);
    do_rd(9, 3'd2, 32'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule